// File: doc/BRIEF.md
# Instruction Cache with Block Invalidate

This block is a read-only instruction cache that holds 32 KiB of code as 128 sets of 8 ways, each line holding 32 bytes (eight 32-bit words). A fetch port asks for one aligned word at a time. A lookup that finds a valid line answers from the cache. A lookup that finds nothing valid stalls the fetch port and requests the whole line from a 256-bit memory port. The returned line is installed, and the requested word is passed back.

Each line carries one valid bit and no other state. When software has rewritten code in memory, it sends a block-invalidate command with the address of the rewritten code. The cache aligns that address down to its line and clears the valid bit of the matching line, if one is present. The command never loads anything. The cache is filled only by fetch misses. An invalidate that names the line being refilled marks that line so that it is installed invalid. The next fetch of that line then goes back to memory.

Top module: `icache_blkinv`

## Requirements
- R1: With the default parameters there are 128 sets, 8 ways and 32-byte lines. Address bits [31:12] are the tag, bits [11:5] select the set, bits [4:2] select the word, and bits [1:0] are ignored. Word j of a line travels on mem_rdata[32*j+31:32*j].
- R2: While reset is held, and directly after it is released, fetch_busy, fetch_rvalid and mem_req are low, and every line is invalid.
- R3: A fetch is accepted in a cycle where fetch_req is high and fetch_busy is low. On a hit, fetch_rvalid is high for exactly the next cycle with the cached word, and mem_req stays low.
- R4: On a miss, mem_req and fetch_busy are high from the next cycle. mem_addr holds the line address with bits [4:0] zero and does not change until mem_rvalid is seen. In the cycle after mem_rvalid, fetch_rvalid carries the requested word from mem_rdata, fetch_busy and mem_req are low, and the line is installed valid.
- R5: A line whose valid bit is clear is treated as absent even when its tag matches, and no two ways of one set ever match the same address.
- R6: An inv_req pulse clears the valid bit of the line that holds inv_addr, after inv_addr has been aligned down to 32 bytes. The next fetch of that line goes to memory.
- R7: An invalidate whose line is not present changes nothing: lines that hit before it still hit after it.
- R8: An invalidate never raises mem_req and never installs a line. Without an accepted fetch, mem_req stays low.
- R9: A fill picks the lowest-numbered invalid way of the set. If every way is valid, it picks the way given by a 7-node tree held per set. Node 1 is the root and node n has children 2n and 2n+1. A node at 0 sends the search to the lower-numbered half, and a node at 1 sends it to the upper half. Every hit or fill of way w sets each node on its path to point away from w. All nodes reset to 0. The victim is fixed when the miss is accepted.
- R10: An invalidate of the line being refilled, made in any cycle from the one in which the fetch is accepted through the one in which mem_rvalid is seen, still returns the word from memory. The line, however, is installed invalid.
- R11: An invalidate of a line in the same cycle as a fetch that hits it returns the cached word, and leaves the line invalid afterwards.
- R12: An invalidate of a different line during a refill takes effect as usual and does not disturb the refill. If it names the old contents of the chosen victim way, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 32 | Byte address of the word to fetch |
| fetch_busy | output | 1 | High while a refill is in progress; no fetch is accepted |
| fetch_rvalid | output | 1 | One-cycle pulse that marks fetch_rdata as valid |
| fetch_rdata | output | 32 | Fetched instruction word |
| inv_req | input | 1 | Block-invalidate command, one cycle per command |
| inv_addr | input | 32 | Any byte address inside the line to invalidate |
| mem_req | output | 1 | Line read request, held until mem_rvalid |
| mem_addr | output | 32 | Line-aligned address of the line being read |
| mem_rvalid | input | 1 | Memory returns the line in this cycle |
| mem_rdata | input | 256 | Line data, word 0 in the lowest bits |

## Verification
An invalidate can arrive in the same cycle as an accepted fetch, either a hit or a miss, and in any cycle of a refill, including the cycle in which memory returns the line. The bench produces these collisions with a fetch task that drives an invalidate a chosen number of cycles after the request: zero for the same cycle, and later values to land inside the refill window. It also aims the invalidate at the same line, at a different line of the same set, or at random pool addresses. A reference model in the bench applies the fetch lookup first and the invalidate after it. It gives the refilled line an invalid state whenever its own line was named before the fill edge. The bench then judges each collision by the returned word and by whether the next fetch of that line raises mem_req.

// File: rtl/icb_pkg.sv
package icb_pkg;

  // Controller state: idle and accepting fetches, or waiting on a line refill
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } icb_state_e;

endpackage

// File: rtl/icb_tag_array.sv
module icb_tag_array #(
  parameter int SETS  = 128,
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // fetch lookup port
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  lk_hit,
  output logic [WAYS-1:0]  lk_valid,
  // invalidate lookup and clear port
  input  logic             iv_en,
  input  logic [IDX_W-1:0] iv_idx,
  input  logic [TAG_W-1:0] iv_tag,
  output logic [WAYS-1:0]  iv_hit,
  // install port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  // Tag storage: datapath, written only on install, no reset
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end

  // Valid bits: the invalidate clear is applied first, then an install to the same way overrides it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (iv_en) vld_q[iv_idx] <= vld_q[iv_idx] & ~iv_hit;
      if (wr_en) vld_q[wr_idx][wr_way] <= wr_valid;
    end
  end

  assign lk_valid = vld_q[lk_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hit[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    assign iv_hit[w] = vld_q[iv_idx][w] && (tag_q[iv_idx][w] == iv_tag);
  end

  // R5: an address never matches more than one valid way
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit) && $onehot0(iv_hit));

  // R6: a matched invalidate leaves the way invalid unless the same set is installed at that edge
  assert_inv_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_en && (|iv_hit) && !(wr_en && (wr_idx == iv_idx)))
    |=> ((vld_q[$past(iv_idx)] & $past(iv_hit)) == '0));

endmodule

// File: rtl/icb_plru.sv
module icb_plru #(
  parameter int SETS  = 128,
  parameter int WAYS  = 8,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [WAYS-1:0]  rd_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [WAY_W-1:0] up_way
);

  // Heap-ordered tree nodes 1..WAYS-1 for each set
  logic [WAYS-1:1] tree_q [SETS];
  logic [WAYS-1:1] tree_d;

  function automatic logic [WAY_W-1:0] tree_pick(input logic [WAYS-1:1] t);
    logic [WAY_W:0] n;
    n = {{WAY_W{1'b0}}, 1'b1};
    for (int l = 0; l < WAY_W; l++) n = {n[WAY_W-1:0], t[n[WAY_W-1:0]]};
    return n[WAY_W-1:0];
  endfunction

  function automatic logic [WAYS-1:1] tree_touch(input logic [WAYS-1:1] t,
                                                 input logic [WAY_W-1:0] way);
    logic [WAY_W:0]   n;
    logic [WAY_W-1:0] w;
    logic             dir;
    logic [WAYS-1:1]  r;
    r = t;
    w = way;
    n = {{WAY_W{1'b0}}, 1'b1};
    for (int l = 0; l < WAY_W; l++) begin
      dir = w[WAY_W-1];
      r[n[WAY_W-1:0]] = ~dir;
      n = {n[WAY_W-1:0], dir};
      w = w << 1;
    end
    return r;
  endfunction

  // Victim: lowest invalid way, else the tree choice
  always_comb begin
    victim = tree_pick(tree_q[rd_idx]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!rd_valid[w]) victim = WAY_W'(w);
    end
  end

  always_comb tree_d = tree_touch(tree_q[up_idx], up_way);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (up_en) begin
      tree_q[up_idx] <= tree_d;
    end
  end

  // R9: right after a way is used, the tree no longer points at it
  assert_tree_away_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> (tree_pick(tree_q[$past(up_idx)]) != $past(up_way)));

endmodule

// File: rtl/icb_line_store.sv
module icb_line_store #(
  parameter int SETS   = 128,
  parameter int WAYS   = 8,
  parameter int LINE_W = 256,
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS),
  parameter int WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic [WORD_W-1:0] rd_word
);

  localparam int ENTRIES = SETS * WAYS;

  logic [LINE_W-1:0] line_q [ENTRIES];
  logic [LINE_W-1:0] line_rd;

  always_ff @(posedge clk) begin
    if (wr_en) line_q[{wr_idx, wr_way}] <= wr_line;
  end

  assign line_rd = line_q[{rd_idx, rd_way}];
  assign rd_word = line_rd[int'(rd_wsel) * WORD_W +: WORD_W];

endmodule

// File: rtl/icache_blkinv.sv
module icache_blkinv
  import icb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_busy,
  output logic              fetch_rvalid,
  output logic [WORD_W-1:0] fetch_rdata,
  input  logic              inv_req,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LA_W   = ADDR_W - OFF_W;

  // Address fields
  logic [WSEL_W-1:0] f_wsel;
  logic [IDX_W-1:0]  f_idx, i_idx;
  logic [TAG_W-1:0]  f_tag, i_tag;
  logic              unused_low;

  assign f_wsel     = fetch_addr[OFF_W-1:BYTE_W];
  assign f_idx      = fetch_addr[OFF_W+IDX_W-1:OFF_W];
  assign f_tag      = fetch_addr[ADDR_W-1:OFF_W+IDX_W];
  assign i_idx      = inv_addr[OFF_W+IDX_W-1:OFF_W];
  assign i_tag      = inv_addr[ADDR_W-1:OFF_W+IDX_W];
  assign unused_low = ^{fetch_addr[BYTE_W-1:0], inv_addr[OFF_W-1:0]};

  // Registers
  icb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  rq_idx_q;
  logic [TAG_W-1:0]  rq_tag_q;
  logic [WSEL_W-1:0] rq_wsel_q;
  logic [WAY_W-1:0]  vic_q;
  logic              kill_q, kill_d;
  logic              mreq_q, mreq_d;
  logic              rv_q, rv_d;
  logic [WORD_W-1:0] rd_q, rd_d;

  // Lookup results
  logic [WAYS-1:0]   lk_hit, lk_valid, iv_hit;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [WORD_W-1:0] hit_word, fill_word;
  logic              look_hit;

  // Control strobes
  logic idle, accept, take_hit, start_miss, fill_now;
  logic inv_same_fetch, inv_same_req, fill_valid;
  logic up_en;
  logic [IDX_W-1:0] up_idx;
  logic [WAY_W-1:0] up_way;
  logic rd_en;

  assign idle       = (state_q == ST_IDLE);
  assign look_hit   = |lk_hit;
  assign accept     = fetch_req && idle;
  assign take_hit   = accept && look_hit;
  assign start_miss = accept && !look_hit;
  assign fill_now   = (state_q == ST_FILL) && mem_rvalid;

  assign inv_same_fetch = inv_req && (inv_addr[ADDR_W-1:OFF_W] == fetch_addr[ADDR_W-1:OFF_W]);
  assign inv_same_req   = inv_req && (inv_addr[ADDR_W-1:OFF_W] == LA_W'({rq_tag_q, rq_idx_q}));
  assign fill_valid     = !(kill_q || inv_same_req);

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign fill_word = mem_rdata[int'(rq_wsel_q) * WORD_W +: WORD_W];

  // Replacement update: a hit in idle or a fill in refill, never both
  assign up_en  = take_hit || fill_now;
  assign up_idx = fill_now ? rq_idx_q : f_idx;
  assign up_way = fill_now ? vic_q : hit_way;

  icb_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_idx  (f_idx),
    .lk_tag  (f_tag),
    .lk_hit  (lk_hit),
    .lk_valid(lk_valid),
    .iv_en   (inv_req),
    .iv_idx  (i_idx),
    .iv_tag  (i_tag),
    .iv_hit  (iv_hit),
    .wr_en   (fill_now),
    .wr_idx  (rq_idx_q),
    .wr_way  (vic_q),
    .wr_tag  (rq_tag_q),
    .wr_valid(fill_valid)
  );

  icb_plru #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_plru (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (f_idx),
    .rd_valid(lk_valid),
    .victim  (victim),
    .up_en   (up_en),
    .up_idx  (up_idx),
    .up_way  (up_way)
  );

  icb_line_store #(
    .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W), .WSEL_W(WSEL_W)
  ) u_lines (
    .clk    (clk),
    .wr_en  (fill_now),
    .wr_idx (rq_idx_q),
    .wr_way (vic_q),
    .wr_line(mem_rdata),
    .rd_idx (f_idx),
    .rd_way (hit_way),
    .rd_wsel(f_wsel),
    .rd_word(hit_word)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    kill_d  = kill_q;
    mreq_d  = mreq_q;
    rv_d    = 1'b0;
    rd_d    = rd_q;
    rd_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_miss) begin
          state_d = ST_FILL;
          mreq_d  = 1'b1;
          kill_d  = inv_same_fetch;
        end else if (take_hit) begin
          rv_d  = 1'b1;
          rd_d  = hit_word;
          rd_en = 1'b1;
        end
      end
      ST_FILL: begin
        kill_d = kill_q || inv_same_req;
        if (mem_rvalid) begin
          state_d = ST_IDLE;
          mreq_d  = 1'b0;
          kill_d  = 1'b0;
          rv_d    = 1'b1;
          rd_d    = fill_word;
          rd_en   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kill_q  <= 1'b0;
      mreq_q  <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kill_q  <= kill_d;
      mreq_q  <= mreq_d;
      rv_q    <= rv_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (start_miss) begin
      rq_idx_q  <= f_idx;
      rq_tag_q  <= f_tag;
      rq_wsel_q <= f_wsel;
      vic_q     <= victim;
    end
    if (rd_en) rd_q <= rd_d;
  end

  assign fetch_busy   = !idle;
  assign fetch_rvalid = rv_q;
  assign fetch_rdata  = rd_q;
  assign mem_req      = mreq_q;
  assign mem_addr     = {rq_tag_q, rq_idx_q, {OFF_W{1'b0}}};

  // R3: a hit answers in the next cycle without touching memory
  assert_hit_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_hit |=> (fetch_rvalid && !mem_req && !fetch_busy));

  // R4: a miss raises the memory request and stalls the fetch port
  assert_miss_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_miss |=> (mem_req && fetch_busy && !fetch_rvalid));

  // R4: the memory address is held until the line returns
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R4: a returned line ends the refill and answers the fetch
  assert_fill_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now |=> (fetch_rvalid && !fetch_busy && !mem_req));

  // R8: without an accepted fetch, no memory request starts
  assert_no_cmd_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !accept) |=> !mem_req);

endmodule

// File: tb/icache_blkinv_test.sv
`timescale 1ns/1ps
module icache_blkinv_test;

  logic         clk;
  logic         rst_n;
  logic         fetch_req;
  logic [31:0]  fetch_addr;
  logic         fetch_busy;
  logic         fetch_rvalid;
  logic [31:0]  fetch_rdata;
  logic         inv_req;
  logic [31:0]  inv_addr;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid;
  logic [255:0] mem_rdata;

  int total = 0;
  int bad   = 0;
  int gen   = 0;
  int lat   = 0;

  // Reference model
  logic [19:0] m_tag  [128][8];
  bit          m_vld  [128][8];
  int          m_gen  [128][8];
  bit [7:0]    m_tree [128];

  icache_blkinv uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_busy(fetch_busy),
    .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata),
    .inv_req(inv_req), .inv_addr(inv_addr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int word, input int lo);
    logic [31:0] t, s, w, l;
    t = tag; s = set; w = word; l = lo;
    return {t[19:0], s[6:0], w[2:0], l[1:0]};
  endfunction

  function automatic logic [31:0] memword(input logic [31:0] line, input int j, input int g);
    logic [31:0] jj, gg;
    jj = j; gg = g;
    return (line * 32'h9E3779B1) ^ (jj * 32'h01010101) ^ (gg * 32'h7F4A7C15);
  endfunction

  function automatic int m_find(input logic [31:0] a);
    int s;
    s = int'(a[11:5]);
    for (int w = 0; w < 8; w++)
      if (m_vld[s][w] && m_tag[s][w] == a[31:12]) return w;
    return -1;
  endfunction

  function automatic int m_victim(input int s);
    int n;
    for (int w = 0; w < 8; w++) if (!m_vld[s][w]) return w;
    n = 1;
    for (int l = 0; l < 3; l++) n = 2 * n + int'(m_tree[s][n]);
    return n - 8;
  endfunction

  task automatic m_touch(input int s, input int w);
    int n, dir;
    n = 1;
    for (int l = 0; l < 3; l++) begin
      dir = (w >> (2 - l)) & 1;
      m_tree[s][n] = (dir == 0);
      n = 2 * n + dir;
    end
  endtask

  task automatic m_inv(input logic [31:0] a);
    int w;
    w = m_find(a);
    if (w >= 0) m_vld[int'(a[11:5])][w] = 1'b0;
  endtask

  // Memory responder: answers after three cycles of mem_req
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
      end else if (rst_n && mem_req) begin
        lat++;
        if (lat >= 3) begin
          lat = 0;
          mem_rvalid = 1'b1;
          for (int j = 0; j < 8; j++) mem_rdata[j*32 +: 32] = memword(mem_addr >> 5, j, gen);
        end
      end
    end
  end

  // One fetch. inv_k < 0: no invalidate; 0: same cycle as the request; k: k cycles later
  task automatic do_fetch(input logic [31:0] a, input int inv_k, input logic [31:0] ia,
                          input string rq, output bit missed);
    int s, w, vic, cyc;
    bit kill;
    logic [31:0] exp;
    s    = int'(a[11:5]);
    w    = m_find(a);
    vic  = (w < 0) ? m_victim(s) : 0;
    kill = 1'b0;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    if (inv_k == 0) begin inv_req = 1'b1; inv_addr = ia; end
    @(negedge clk);
    fetch_req = 1'b0;
    inv_req   = 1'b0;
    missed    = mem_req;
    if (w >= 0) begin
      exp = memword(a >> 5, int'(a[4:2]), m_gen[s][w]);
      check(mem_req == 1'b0, {rq, " R3 hit must not request memory"}, 32'(mem_req), 32'd0);
      check(fetch_rvalid == 1'b1, {rq, " R3 hit reply"}, 32'(fetch_rvalid), 32'd1);
      check(fetch_rdata == exp, {rq, " R3 hit data"}, fetch_rdata, exp);
      m_touch(s, w);
      if (inv_k == 0) m_inv(ia);
    end else begin
      if (inv_k == 0) begin
        if (ia[31:5] == a[31:5]) kill = 1'b1;
        m_inv(ia);
      end
      check(mem_req == 1'b1 && fetch_busy == 1'b1, {rq, " R4 miss request"}, 32'(mem_req), 32'd1);
      check(mem_addr == {a[31:5], 5'b0}, {rq, " R4 line address"}, mem_addr, {a[31:5], 5'b0});
      cyc = 1;
      while (fetch_rvalid !== 1'b1 && cyc < 50) begin
        if (inv_k == cyc) begin
          inv_req  = 1'b1;
          inv_addr = ia;
          if (ia[31:5] == a[31:5]) kill = 1'b1;
          m_inv(ia);
        end
        @(negedge clk);
        inv_req = 1'b0;
        cyc++;
      end
      exp = memword(a >> 5, int'(a[4:2]), gen);
      check(fetch_rvalid == 1'b1, {rq, " R4 refill reply"}, 32'(fetch_rvalid), 32'd1);
      check(fetch_rdata == exp, {rq, " R4 R1 refill data"}, fetch_rdata, exp);
      check(fetch_busy == 1'b0 && mem_req == 1'b0, {rq, " R4 refill end"}, 32'(fetch_busy), 32'd0);
      m_tag[s][vic] = a[31:12];
      m_vld[s][vic] = !kill;
      m_gen[s][vic] = gen;
      m_touch(s, vic);
    end
  endtask

  task automatic do_inv(input logic [31:0] a);
    @(negedge clk);
    inv_req  = 1'b1;
    inv_addr = a;
    @(negedge clk);
    inv_req = 1'b0;
    m_inv(a);
    check(mem_req == 1'b0 && fetch_rvalid == 1'b0, "R8 invalidate loads nothing", 32'(mem_req), 32'd0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit m;
    int sets_pool [4];
    logic [31:0] a, b, c;
    sets_pool = '{0, 1, 77, 127};
    void'($urandom(32'd4711));
    for (int s = 0; s < 128; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < 8; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_gen[s][w] = 0; end
    end
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0; inv_req = 1'b0; inv_addr = '0;
    repeat (3) @(negedge clk);
    check(!fetch_busy && !fetch_rvalid && !mem_req, "R2 outputs low in reset", 32'(fetch_busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!fetch_busy && !fetch_rvalid && !mem_req, "R2 outputs low after reset", 32'(mem_req), 32'd0);

    // R1, R2, R3, R4: first fetch misses; other words and the top address map correctly
    a = mk(5, 9, 7, 2);
    do_fetch(a, -1, 0, "R2", m);
    check(m == 1'b1, "R2 cold cache misses", 32'(m), 32'd1);
    do_fetch(mk(5, 9, 0, 0), -1, 0, "R1", m);
    check(m == 1'b0, "R3 same line hits", 32'(m), 32'd0);
    do_fetch(32'hFFFF_FFFC, -1, 0, "R1", m);
    do_fetch(32'hFFFF_FFE1, -1, 0, "R1", m);
    check(m == 1'b0, "R1 low bits ignored", 32'(m), 32'd0);

    // R6: unaligned invalidate clears the line
    do_inv(mk(5, 9, 7, 3));
    do_fetch(a, -1, 0, "R6", m);
    check(m == 1'b1, "R6 refetch after invalidate misses", 32'(m), 32'd1);

    // R7: invalidate of an absent line is a no-op
    do_inv(mk(6, 9, 3, 0));
    do_fetch(a, -1, 0, "R7", m);
    check(m == 1'b0, "R7 line still hits", 32'(m), 32'd0);

    // R9: fill a set, age it, evict by the tree, then prefer an invalid way
    for (int t = 0; t < 8; t++) do_fetch(mk(t, 3, t, 0), -1, 0, "R9", m);
    for (int t = 0; t < 8; t++) begin
      do_fetch(mk(t, 3, 0, 0), -1, 0, "R9", m);
      check(m == 1'b0, "R9 full set all hit", 32'(m), 32'd0);
    end
    begin
      int v;
      logic [19:0] old;
      v = m_victim(3);
      old = m_tag[3][v];
      do_fetch(mk(8, 3, 1, 0), -1, 0, "R9", m);
      do_fetch({old, 7'd3, 5'd0}, -1, 0, "R9", m);
      check(m == 1'b1, "R9 tree victim was evicted", 32'(m), 32'd1);
    end
    do_inv(mk(2, 3, 0, 0));
    do_fetch(mk(9, 3, 0, 0), -1, 0, "R9", m);
    for (int w = 0; w < 8; w++) begin
      do_fetch({m_tag[3][w], 7'd3, 5'd4}, -1, 0, "R9", m);
      check(m == 1'b0, "R9 invalid way preferred", 32'(m), 32'd0);
    end

    // R10: invalidate of the refilling line at several points of the refill
    for (int k = 0; k < 4; k++) begin
      b = mk(40 + k, 20, 2, 0);
      gen++;
      do_fetch(b, k, mk(40 + k, 20, 6, 1), "R10", m);
      do_fetch(b, -1, 0, "R10", m);
      check(m == 1'b1, "R10 killed line is refetched", 32'(m), 32'd1);
    end

    // R11: invalidate in the same cycle as a hit
    c = mk(50, 21, 4, 0);
    do_fetch(c, -1, 0, "R11", m);
    do_fetch(c, 0, c, "R11", m);
    check(m == 1'b0, "R11 cached word served", 32'(m), 32'd0);
    do_fetch(c, -1, 0, "R11", m);
    check(m == 1'b1, "R11 line invalid afterwards", 32'(m), 32'd1);

    // R12: invalidate of another line during a refill
    do_fetch(mk(51, 21, 0, 0), 2, c, "R12", m);
    do_fetch(c, -1, 0, "R12", m);
    check(m == 1'b1, "R12 other line invalidated", 32'(m), 32'd1);
    do_fetch(mk(51, 21, 5, 0), -1, 0, "R12", m);
    check(m == 1'b0, "R12 refilled line valid", 32'(m), 32'd0);

    // Random mix of fetches, invalidates, collisions and code rewrites
    for (int i = 0; i < 600; i++) begin
      int op, k;
      logic [31:0] ra, rb;
      op = int'($urandom_range(0, 99));
      ra = mk(int'($urandom_range(0, 11)), sets_pool[$urandom_range(0, 3)],
              int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
      rb = mk(int'($urandom_range(0, 11)), sets_pool[$urandom_range(0, 3)],
              int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
      if (op < 55) begin
        do_fetch(ra, -1, 0, "R5", m);
      end else if (op < 75) begin
        k = int'($urandom_range(0, 3));
        if ($urandom_range(0, 1) == 1) rb = {ra[31:5], rb[4:0]};
        do_fetch(ra, k, rb, "R10 R12", m);
      end else if (op < 92) begin
        do_inv(rb);
      end else begin
        gen++;
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule